// File: doc/BRIEF.md
# UART Automatic Baud-Rate Detector

This block works out the bit time of a serial character arriving on a UART receive line. It then produces the divisor that sets the receiver's 16x oversampling clock. Software arms a measurement with a start pulse and may abort it with a clear pulse. While armed, the detector waits for a falling edge on the synchronised receive line and counts elapsed clock cycles in units of sixteen.

The measurement ends on one of two edges, chosen by the mode input:
- In mode 0 it ends on the next falling edge. For an "A" or "a" character, this edge closes the least significant data bit, so the span is two bit times.
- In mode 1 it ends on the first rising edge, so the span is the start bit alone.

When the measurement ends, the detector loads the divisor, drops its busy status and may raise an end interrupt.

If the measurement counter wraps, a timeout occurs. The detector then stops, or, with auto-restart enabled, re-arms and waits for the next falling edge. Two sticky interrupt flags record the timeout and a successful finish. Each flag has its own enable and its own clear input. While busy, the detector also asserts an override that forces the fractional divider off and runs the receiver at its fastest sampling rate.

Top module: `uart_baud_detect`

## Requirements
- R1: A pulse on `start_set_i` makes `busy_o` read 1 from the next clock edge. It resets the measurement count, and `busy_o` returns to 0 by itself once a measurement completes.
- R2: A pulse on `start_clr_i` makes `busy_o` read 0 from the next edge. It has priority over `start_set_i` in the same cycle, leaves `divisor_o` unchanged and raises neither flag.
- R3: With `mode_i`=0, let T be the number of clock cycles between the first falling edge and the next falling edge. The divisor becomes floor(floor(T/16)/2). For a character whose bit time is B cycles, this equals floor(B/16).
- R4: With `mode_i`=1, let T be the number of clock cycles from the falling edge to the next rising edge. The divisor becomes floor(T/16).
- R5: A computed divisor of 0 is written as 1. `divisor_o` resets to 1 and is never 0.
- R6: When no ending edge arrives within 16·2^CNT_W − 1 cycles of the falling edge, the counter wraps and a timeout occurs. With `restart_en_i`=0, `busy_o` falls and `divisor_o` keeps its previous value.
- R7: With `restart_en_i`=1, a timeout leaves `busy_o` at 1. A fresh measurement starts at the next falling edge.
- R8: If the ending edge arrives in the same cycle as the counter wrap, the measurement counts as a success. Its result uses the count before the wrap, and no timeout occurs.
- R9: `to_irq_o` sets on a timeout only while `to_ien_i`=1. It stays set until `to_clr_i` is high on a clock edge, and a timeout in the same cycle as the clear wins.
- R10: `end_irq_o` sets on a successful finish only while `end_ien_i`=1. It stays set until `end_clr_i` is high on a clock edge, and a finish in the same cycle wins.
- R11: `rate_override_o` is 1 exactly while `busy_o` is 1.
- R12: After reset, `busy_o`=0, `divisor_o`=1, `to_irq_o`=0, `end_irq_o`=0 and `rate_override_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (PCLK) |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_i | input | 1 | Asynchronous serial receive line |
| start_set_i | input | 1 | Pulse: arm a measurement |
| start_clr_i | input | 1 | Pulse: abort a measurement |
| mode_i | input | 1 | 0: falling-to-falling, 1: falling-to-rising |
| restart_en_i | input | 1 | Re-arm after a timeout |
| to_ien_i | input | 1 | Timeout flag enable |
| end_ien_i | input | 1 | End flag enable |
| to_clr_i | input | 1 | Clear timeout flag |
| end_clr_i | input | 1 | Clear end flag |
| divisor_o | output | CNT_W | Divisor result |
| busy_o | output | 1 | Measurement pending |
| rate_override_o | output | 1 | Fractional divider off, fastest sampling |
| to_irq_o | output | 1 | Sticky timeout flag |
| end_irq_o | output | 1 | Sticky end flag |

## Verification
Two pairs of events can land in the same cycle: an ending edge with the counter wrap, and a flag's setting event with its clear. The bench places a mode-1 rising edge exactly 16·2^CNT_W − 1 cycles after the falling edge. It then expects the full pre-wrap count as the divisor, an end flag and no timeout flag. It also holds the timeout clear high across a whole timeout and samples the flag in the wrap cycle and in the cycle after. The flag must read 1 in the wrap cycle and 0 one cycle later.

// File: rtl/abd_pkg.sv
package abd_pkg;

    typedef enum logic [1:0] {
        ABD_IDLE = 2'd0,
        ABD_ARM  = 2'd1,
        ABD_MEAS = 2'd2
    } abd_state_e;

    typedef struct packed {
        logic fall;
        logic rise;
    } abd_edge_t;

endpackage

// File: rtl/abd_rx_edge.sv
module abd_rx_edge
    import abd_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      rx_i,
    output abd_edge_t edge_o
);
    localparam int CHAIN_W = SYNC_STAGES + 1;

    typedef struct packed {
        logic [CHAIN_W-1:0] sh;
    } sync_t;

    sync_t r_d, r_q;
    logic  rx_now, rx_prev;

    always_comb begin
        r_d    = r_q;
        r_d.sh = {r_q.sh[CHAIN_W-2:0], rx_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{sh: '1};
        else        r_q <= r_d;
    end

    assign rx_now      = r_q.sh[SYNC_STAGES-1];
    assign rx_prev     = r_q.sh[SYNC_STAGES];
    assign edge_o.fall = rx_prev & ~rx_now;
    assign edge_o.rise = ~rx_prev & rx_now;

endmodule

// File: rtl/abd_meas_core.sv
module abd_meas_core
    import abd_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PRE_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  abd_edge_t        edge_i,
    input  logic             start_set_i,
    input  logic             start_clr_i,
    input  logic             mode_i,
    input  logic             restart_en_i,
    output logic             busy_o,
    output logic [CNT_W-1:0] div_o,
    output logic             done_evt_o,
    output logic             to_evt_o
);
    typedef struct packed {
        abd_state_e       st;
        logic [PRE_W-1:0] pre;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] div;
    } core_t;

    core_t            r_d, r_q;
    logic             end_edge, pre_wrap, cnt_full;
    logic [CNT_W-1:0] result;

    always_comb begin
        r_d        = r_q;
        done_evt_o = 1'b0;
        to_evt_o   = 1'b0;
        end_edge   = mode_i ? edge_i.rise : edge_i.fall;
        pre_wrap   = &r_q.pre;
        cnt_full   = &r_q.cnt;
        result     = mode_i ? r_q.cnt : (r_q.cnt >> 1);

        if (start_clr_i) begin
            r_d.st = ABD_IDLE;
        end else if (start_set_i) begin
            r_d.st  = ABD_ARM;
            r_d.pre = '0;
            r_d.cnt = '0;
        end else begin
            case (r_q.st)
                ABD_ARM: begin
                    if (edge_i.fall) begin
                        r_d.st  = ABD_MEAS;
                        r_d.pre = PRE_W'(1);
                        r_d.cnt = '0;
                    end
                end
                ABD_MEAS: begin
                    if (end_edge) begin
                        done_evt_o = 1'b1;
                        r_d.st     = ABD_IDLE;
                        r_d.div    = (result == '0) ? CNT_W'(1) : result;
                    end else begin
                        r_d.pre = r_q.pre + PRE_W'(1);
                        if (pre_wrap) begin
                            r_d.cnt = r_q.cnt + CNT_W'(1);
                            if (cnt_full) begin
                                to_evt_o = 1'b1;
                                r_d.st   = restart_en_i ? ABD_ARM : ABD_IDLE;
                            end
                        end
                    end
                end
                default: r_d.st = ABD_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: ABD_IDLE, pre: '0, cnt: '0, div: CNT_W'(1)};
        else        r_q <= r_d;
    end

    assign busy_o = (r_q.st != ABD_IDLE);
    assign div_o  = r_q.div;

    assert_start_arms_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (start_set_i && !start_clr_i) |=> (r_q.st == ABD_ARM));
    assert_clear_aborts_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start_clr_i |=> !busy_o);
    assert_div_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        div_o != '0);
    assert_div_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !done_evt_o |=> $stable(div_o));
    assert_events_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done_evt_o, to_evt_o}));

endmodule

// File: rtl/abd_irq.sv
module abd_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic to_evt_i,
    input  logic done_evt_i,
    input  logic to_ien_i,
    input  logic end_ien_i,
    input  logic to_clr_i,
    input  logic end_clr_i,
    output logic to_irq_o,
    output logic end_irq_o
);
    typedef struct packed {
        logic to_flag;
        logic end_flag;
    } irq_t;

    irq_t r_d, r_q;

    always_comb begin
        r_d          = r_q;
        r_d.to_flag  = (r_q.to_flag & ~to_clr_i) | (to_evt_i & to_ien_i);
        r_d.end_flag = (r_q.end_flag & ~end_clr_i) | (done_evt_i & end_ien_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign to_irq_o  = r_q.to_flag;
    assign end_irq_o = r_q.end_flag;

    assert_to_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!to_irq_o && !to_ien_i) |=> !to_irq_o);
    assert_to_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (to_evt_i && to_ien_i) |=> to_irq_o);
    assert_end_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!end_irq_o && !end_ien_i) |=> !end_irq_o);
    assert_end_sets_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done_evt_i && end_ien_i) |=> end_irq_o);

endmodule

// File: rtl/uart_baud_detect.sv
module uart_baud_detect
    import abd_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int OVERSAMPLE  = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_i,
    input  logic             start_set_i,
    input  logic             start_clr_i,
    input  logic             mode_i,
    input  logic             restart_en_i,
    input  logic             to_ien_i,
    input  logic             end_ien_i,
    input  logic             to_clr_i,
    input  logic             end_clr_i,
    output logic [CNT_W-1:0] divisor_o,
    output logic             busy_o,
    output logic             rate_override_o,
    output logic             to_irq_o,
    output logic             end_irq_o
);
    localparam int PRE_W = $clog2(OVERSAMPLE);

    abd_edge_t rx_edge;
    logic      done_evt, to_evt;

    abd_rx_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .rx_i   (rx_i),
        .edge_o (rx_edge)
    );

    abd_meas_core #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_core (
        .clk          (clk),
        .rst_n        (rst_n),
        .edge_i       (rx_edge),
        .start_set_i  (start_set_i),
        .start_clr_i  (start_clr_i),
        .mode_i       (mode_i),
        .restart_en_i (restart_en_i),
        .busy_o       (busy_o),
        .div_o        (divisor_o),
        .done_evt_o   (done_evt),
        .to_evt_o     (to_evt)
    );

    abd_irq u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .to_evt_i   (to_evt),
        .done_evt_i (done_evt),
        .to_ien_i   (to_ien_i),
        .end_ien_i  (end_ien_i),
        .to_clr_i   (to_clr_i),
        .end_clr_i  (end_clr_i),
        .to_irq_o   (to_irq_o),
        .end_irq_o  (end_irq_o)
    );

    assign rate_override_o = busy_o;

    assert_no_end_while_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_set_i) |=> !busy_o);

endmodule

// File: tb/tb_uart_baud_detect.sv
module tb_uart_baud_detect;
    localparam int CW = 8;
    localparam int WRAP_T = 16 * (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rx = 1'b1;
    logic          start_set = 1'b0, start_clr = 1'b0, mode = 1'b0, restart_en = 1'b0;
    logic          to_ien = 1'b0, end_ien = 1'b0, to_clr = 1'b0, end_clr = 1'b0;
    logic [CW-1:0] divisor;
    logic          busy, override, to_irq, end_irq;

    int errors = 0;
    int checks = 0;
    bit ended  = 0;
    int last_div = 1;

    uart_baud_detect #(.CNT_W(CW)) dut (
        .clk(clk), .rst_n(rst_n), .rx_i(rx),
        .start_set_i(start_set), .start_clr_i(start_clr), .mode_i(mode),
        .restart_en_i(restart_en), .to_ien_i(to_ien), .end_ien_i(end_ien),
        .to_clr_i(to_clr), .end_clr_i(end_clr),
        .divisor_o(divisor), .busy_o(busy), .rate_override_o(override),
        .to_irq_o(to_irq), .end_irq_o(end_irq)
    );

    always #10 clk = ~clk;

    function automatic int exp_div(int b);
        int v = b / 16;
        return (v == 0) ? 1 : v;
    endfunction

    task automatic chk(string rq, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
        end
    endtask

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_start();
        @(negedge clk); start_set = 1'b1;
        @(negedge clk); start_set = 1'b0;
    endtask

    task automatic send_char(int b);
        rx = 1'b0; wait_n(b);
        rx = 1'b1; wait_n(b);
        rx = 1'b0; wait_n(b);
        rx = 1'b1; wait_n(b + 20);
    endtask

    task automatic measure(int b, logic m);
        mode = m;
        pulse_start();
        chk("R1", busy, 1);
        chk("R11", override, 1);
        send_char(b);
        last_div = exp_div(b);
        chk(m ? "R4" : "R3", divisor, last_div);
        chk("R1", busy, 0);
        chk("R11", override, 0);
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(20 * 190000);
        errors++;
        $display("FAIL watchdog: actual 1 expected 0");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5eed_0a1b));
        wait_n(4);
        chk("R12", busy, 0);
        chk("R12", divisor, 1);
        chk("R12", to_irq, 0);
        chk("R12", end_irq, 0);
        chk("R12", override, 0);
        rst_n = 1'b1;
        wait_n(3);

        // directed mode 0 and mode 1
        end_ien = 1'b1;
        measure(160, 1'b0);
        chk("R10", end_irq, 1);
        @(negedge clk); end_clr = 1'b1;
        @(negedge clk); end_clr = 1'b0;
        chk("R10", end_irq, 0);
        end_ien = 1'b0;
        measure(48, 1'b1);
        chk("R10", end_irq, 0);
        measure(7, 1'b1);               // R5 zero result
        chk("R5", divisor, 1);

        // random bit times and modes
        end_ien = 1'b1;
        for (int i = 0; i < 8; i++) begin
            int  b = 16 + int'($urandom % 600);
            logic m = logic'($urandom % 2);
            measure(b, m);
            chk("R10", end_irq, 1);
            @(negedge clk); end_clr = 1'b1;
            @(negedge clk); end_clr = 1'b0;
        end

        // R2 abort mid measurement
        pulse_start();
        rx = 1'b0; wait_n(50);
        start_clr = 1'b1; @(negedge clk); start_clr = 1'b0;
        chk("R2", busy, 0);
        chk("R2", divisor, last_div);
        rx = 1'b1; wait_n(20);
        chk("R2", end_irq, 0);
        chk("R2", to_irq, 0);

        // R2 clear beats set
        @(negedge clk); start_set = 1'b1; start_clr = 1'b1;
        @(negedge clk); start_set = 1'b0; start_clr = 1'b0;
        chk("R2", busy, 0);

        // R6 timeout without restart, R9 flag
        to_ien = 1'b1; mode = 1'b0;
        pulse_start();
        rx = 1'b0; wait_n(WRAP_T + 20);
        chk("R6", busy, 0);
        chk("R6", divisor, last_div);
        chk("R9", to_irq, 1);
        rx = 1'b1; wait_n(5);
        @(negedge clk); to_clr = 1'b1;
        @(negedge clk); to_clr = 1'b0;
        chk("R9", to_irq, 0);

        // R9 gated by enable
        to_ien = 1'b0;
        pulse_start();
        rx = 1'b0; wait_n(WRAP_T + 20);
        chk("R9", to_irq, 0);
        chk("R6", busy, 0);
        rx = 1'b1; wait_n(5);

        // R9 set wins over clear in the same cycle
        to_ien = 1'b1; to_clr = 1'b1;
        pulse_start();
        rx = 1'b0; wait_n(WRAP_T + 3);
        chk("R9", to_irq, 1);
        wait_n(1);
        chk("R9", to_irq, 0);
        to_clr = 1'b0;
        rx = 1'b1; wait_n(5);

        // R7 auto restart
        restart_en = 1'b1;
        pulse_start();
        rx = 1'b0; wait_n(WRAP_T + 20);
        chk("R7", to_irq, 1);
        chk("R7", busy, 1);
        rx = 1'b1; wait_n(20);
        mode = 1'b1;
        send_char(64);
        chk("R7", divisor, 4);
        chk("R7", busy, 0);
        restart_en = 1'b0;
        @(negedge clk); to_clr = 1'b1; end_clr = 1'b1;
        @(negedge clk); to_clr = 1'b0; end_clr = 1'b0;

        // R8 ending edge coincides with counter wrap
        mode = 1'b1;
        pulse_start();
        rx = 1'b0; wait_n(WRAP_T);
        rx = 1'b1; wait_n(20);
        chk("R8", divisor, (1 << CW) - 1);
        chk("R8", end_irq, 1);
        chk("R8", to_irq, 0);
        chk("R8", busy, 0);

        finish_run();
    end
endmodule